// File: doc/BRIEF.md
# Fractional Peripheral Clock Divider

This block derives a slow peripheral timing strobe from one of three source clocks: a crystal reference and two PLL outputs. Each source is presented to the block as a one-cycle tick on the fast system clock, one tick per source period. The chosen source first goes through a pre-divide stage of 2, 2.5 or 3. The pre-divide result then goes through an integer divide-by-N stage. The result is `div_tick`, a one-cycle clock-enable pulse per output period, which downstream logic uses to advance at the derived rate.

A 32-bit configuration word is written through a plain write strobe, and only while a lock-release input is held high. Readback shows the stored word right away. The settings that actually drive the counters live in a working copy. That copy follows the stored word only at an output period boundary, so a change never shortens or splits a period. Stopping is the one exception: it takes effect at once. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `frac_clkdiv`

## Requirements
- R1: After reset the readback word is 0 and `div_tick` stays low.
- R2: A write is stored only when `cfg_wr` and `cfg_unlock` are both high in the same cycle. Otherwise the readback word and the pulse train are unchanged.
- R3: Field layout: bit 31 is enable, bit 30 is the source class (0 = crystal, 1 = PLL), bit 29 is the PLL choice (0 = first, 1 = second), bits 9:8 are the pre-divide code and bits 6:0 are N. All other bits read as 0. Readback shows a write on the next cycle.
- R4: With bit 30 = 0 the crystal tick is counted and bit 29 is ignored. With bit 30 = 1, bit 29 picks `pll1_tick` (0) or `pll2_tick` (1).
- R5: Pre-divide code 01 ends a pre-period every 2 source ticks, and code 11 every 3.
- R6: Pre-divide code 10 ends pre-periods after alternately 2 and 3 source ticks, so the average is 2.5.
- R7: An output period lasts N pre-periods for N from 2 to 127. N = 0 and N = 1 both give one pre-period.
- R8: While enable is 0 or the code is 00, no pulses are produced and the counters are held cleared.
- R9: A setting changed mid-period does not alter that period. The new setting governs from the next period on.
- R10: A write captured on the same clock edge that closes a period starts to apply only after the following period.
- R11: Clearing enable or writing code 00 stops the pulses without waiting for a boundary. No pulse appears later than two clocks after readback shows the change.
- R12: `div_tick` is high for a single cycle, one clock after the source tick that completes the period. Two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than every source |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_unlock | input | 1 | Lock release; must be high together with `cfg_wr` |
| cfg_wdata | input | 32 | Configuration word to write |
| xtal_tick | input | 1 | One-cycle tick per crystal period |
| pll1_tick | input | 1 | One-cycle tick per first PLL period |
| pll2_tick | input | 1 | One-cycle tick per second PLL period |
| cfg_rdata | output | 32 | Stored configuration word |
| div_tick | output | 1 | One-cycle pulse per output period |

## Verification
Two functions can land on the same clock edge: a software write and the closing of an output period, which is also the moment the working copy reloads. The bench runs the crystal path with a 6-cycle period. It counts edges after an observed pulse and lands the write exactly on the closing edge. It then expects intervals of 6, 6, then the new length, because the captured value is not yet stored when the copy reloads. The same write placed one edge earlier must give 6 followed directly by the new length. That contrast shows the reload samples the stored word and not the incoming data.

// File: rtl/frac_clkdiv_pkg.sv
package frac_clkdiv_pkg;

  localparam int CFG_W    = 32;
  localparam int EN_POS   = 31;
  localparam int SRC_POS  = 30;
  localparam int PLL_POS  = 29;
  localparam int PRE_POS  = 8;
  localparam int PRE_W    = 2;
  localparam int NDIV_POS = 0;
  localparam int NSRC     = 3;

  typedef enum logic [1:0] {
    PRE_OFF    = 2'b00,
    PRE_DIV2   = 2'b01,
    PRE_DIV2P5 = 2'b10,
    PRE_DIV3   = 2'b11
  } pre_e;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_PLL1 = 2'd1,
    SRC_PLL2 = 2'd2
  } src_e;

  typedef struct packed {
    logic en;
    logic use_pll;
    logic pll_hi;
    pre_e pre;
  } ctl_t;

  function automatic src_e pick_src(ctl_t c);
    if (!c.use_pll) return SRC_XTAL;
    return c.pll_hi ? SRC_PLL2 : SRC_PLL1;
  endfunction

  function automatic logic ctl_runs(ctl_t c);
    return c.en && (c.pre != PRE_OFF);
  endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import frac_clkdiv_pkg::*;
#(
  parameter int NDIV_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_unlock,
  input  logic [CFG_W-1:0]  wr_data,
  output ctl_t              ctl_q,
  output logic [NDIV_W-1:0] ndiv_q,
  output logic [CFG_W-1:0]  rd_data
);

  logic accept;
  assign accept = wr_en && wr_unlock;

  // Reserved write bits are dropped on purpose.
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      ndiv_q <= '0;
    end else if (accept) begin
      ctl_q.en      <= wr_data[EN_POS];
      ctl_q.use_pll <= wr_data[SRC_POS];
      ctl_q.pll_hi  <= wr_data[PLL_POS];
      ctl_q.pre     <= pre_e'(wr_data[PRE_POS +: PRE_W]);
      ndiv_q        <= wr_data[NDIV_POS +: NDIV_W];
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[EN_POS]             = ctl_q.en;
    rd_data[SRC_POS]            = ctl_q.use_pll;
    rd_data[PLL_POS]            = ctl_q.pll_hi;
    rd_data[PRE_POS +: PRE_W]   = ctl_q.pre;
    rd_data[NDIV_POS +: NDIV_W] = ndiv_q;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);

  assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_unlock) |=> $stable(rd_data));

endmodule

// File: rtl/clkdiv_active.sv
module clkdiv_active
  import frac_clkdiv_pkg::*;
#(
  parameter int NDIV_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              reg_ctl,
  input  logic [NDIV_W-1:0] reg_ndiv,
  input  logic              period_end,
  output ctl_t              act_ctl,
  output logic [NDIV_W-1:0] act_ndiv,
  output logic              act_run
);

  logic reg_run, reload;

  assign reg_run = ctl_runs(reg_ctl);
  assign act_run = ctl_runs(act_ctl);
  // Idle copies follow at once; a running copy waits for a boundary,
  // except that a stop request is honoured immediately.
  assign reload  = !act_run || period_end || !reg_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ctl  <= '0;
      act_ndiv <= '0;
    end else if (reload) begin
      act_ctl  <= reg_ctl;
      act_ndiv <= reg_ndiv;
    end
  end

  assert_hold_mid_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_run && !period_end && ctl_runs(reg_ctl) |=> $stable({act_ctl, act_ndiv}));

endmodule

// File: rtl/clkdiv_prediv.sv
module clkdiv_prediv
  import frac_clkdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [NSRC-1:0] src_ticks,
  input  src_e            sel,
  input  pre_e            code,
  output logic            pre_tick
);

  logic [NSRC-1:0] hit;
  logic            tick;
  logic [1:0]      pcnt, last;
  logic            phase;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_ticks[g] && (sel == src_e'(g));
  end
  assign tick = |hit;

  always_comb begin
    unique case (code)
      PRE_DIV3:   last = 2'd2;
      PRE_DIV2P5: last = phase ? 2'd2 : 2'd1;
      default:    last = 2'd1;
    endcase
  end

  assign pre_tick = run && tick && (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt  <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      if (pre_tick) begin
        pcnt  <= '0;
        phase <= (code == PRE_DIV2P5) ? !phase : 1'b0;
      end else begin
        pcnt <= pcnt + 2'd1;
      end
    end
  end

  assert_prediv_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

  assert_prediv_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == 2'd0) && !phase);

endmodule

// File: rtl/clkdiv_ndiv.sv
module clkdiv_ndiv #(
  parameter int NDIV_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pre_tick,
  input  logic [NDIV_W-1:0] ndiv,
  output logic              period_end
);

  logic [NDIV_W-1:0] ncnt, top;

  assign top        = (ndiv <= NDIV_W'(1)) ? '0 : ndiv - NDIV_W'(1);
  assign period_end = pre_tick && (ncnt == top);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ncnt <= '0;
    end else if (pre_tick) begin
      ncnt <= period_end ? '0 : ncnt + NDIV_W'(1);
    end
  end

  assert_count_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ncnt <= top);

endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv
  import frac_clkdiv_pkg::*;
#(
  parameter int NDIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_unlock,
  input  logic [31:0] cfg_wdata,
  input  logic        xtal_tick,
  input  logic        pll1_tick,
  input  logic        pll2_tick,
  output logic [31:0] cfg_rdata,
  output logic        div_tick
);

  ctl_t              reg_ctl, act_ctl;
  logic [NDIV_W-1:0] reg_ndiv, act_ndiv;
  logic              act_run, pre_tick, period_end;
  logic [NSRC-1:0]   src_ticks;

  assign src_ticks = {pll2_tick, pll1_tick, xtal_tick};

  clkdiv_cfg_reg #(.NDIV_W(NDIV_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_unlock(cfg_unlock),
    .wr_data(cfg_wdata), .ctl_q(reg_ctl), .ndiv_q(reg_ndiv), .rd_data(cfg_rdata)
  );

  clkdiv_active #(.NDIV_W(NDIV_W)) u_act (
    .clk(clk), .rst_n(rst_n), .reg_ctl(reg_ctl), .reg_ndiv(reg_ndiv),
    .period_end(period_end), .act_ctl(act_ctl), .act_ndiv(act_ndiv),
    .act_run(act_run)
  );

  clkdiv_prediv u_pre (
    .clk(clk), .rst_n(rst_n), .run(act_run), .src_ticks(src_ticks),
    .sel(pick_src(act_ctl)), .code(act_ctl.pre), .pre_tick(pre_tick)
  );

  clkdiv_ndiv #(.NDIV_W(NDIV_W)) u_ndiv (
    .clk(clk), .rst_n(rst_n), .run(act_run), .pre_tick(pre_tick),
    .ndiv(act_ndiv), .period_end(period_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) div_tick <= 1'b0;
    else        div_tick <= period_end;
  end

  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_run |=> !div_tick);

  assert_stop_prompt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_runs(reg_ctl) |=> ##1 !div_tick);

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick);

endmodule

// File: tb/frac_clkdiv_test.sv
`timescale 1ns/1ps
module frac_clkdiv_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_unlock = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        xtal_tick = 1'b0, pll1_tick = 1'b0, pll2_tick = 1'b0;
  logic [31:0] cfg_rdata;
  logic        div_tick;

  int errors = 0, checks = 0;
  int cyc = 0, npulse = 0, last_cyc = 0;
  int hist [64];

  always #10 clk = ~clk;

  frac_clkdiv uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_unlock(cfg_unlock),
    .cfg_wdata(cfg_wdata), .xtal_tick(xtal_tick), .pll1_tick(pll1_tick),
    .pll2_tick(pll2_tick), .cfg_rdata(cfg_rdata), .div_tick(div_tick)
  );

  // Source ticks: crystal every cycle, first PLL every 2nd, second PLL every 3rd.
  always @(negedge clk) begin
    xtal_tick <= 1'b1;
    pll1_tick <= (cyc % 2 == 0);
    pll2_tick <= (cyc % 3 == 1);
  end

  // Pulse monitor, sampled just after each rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    if (div_tick) begin
      npulse++;
      hist[npulse % 64] = cyc - last_cyc;
      last_cyc = cyc;
    end
  end

  // Table: config word and total cycles spanned by 8 output intervals.
  localparam logic [31:0] VEC_CFG [8] = '{
    32'h8000_0100, 32'h8000_0301, 32'hC000_0200, 32'hE000_0105,
    32'h8000_0203, 32'hC000_037F, 32'hE000_0202, 32'hA000_0100};
  localparam int VEC_CYC [8] = '{16, 24, 40, 240, 60, 6096, 120, 16};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d, input logic unlock);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_unlock = unlock; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_unlock = 1'b0;
  endtask

  task automatic wait_pulses(input int k);
    int target = npulse + k;
    int guard = 0;
    while (npulse < target && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, np0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1 readback after reset", cfg_rdata, 0);
    repeat (40) @(negedge clk);
    chk(npulse == 0, "R1 no pulses after reset", npulse, 0);

    // R3: field layout, reserved bits read zero
    write_cfg(32'hFFFF_FFFF, 1'b1);
    chk(cfg_rdata == 32'hE000_037F, "R3 field layout", cfg_rdata, 32'hE000_037F);
    write_cfg(32'h0000_0000, 1'b1);
    repeat (4) @(negedge clk);

    // R2: locked write ignored
    np0 = npulse;
    write_cfg(32'h8000_0100, 1'b0);
    repeat (40) @(negedge clk);
    chk(cfg_rdata == 32'h0, "R2 locked write readback", cfg_rdata, 0);
    chk(npulse == np0, "R2 locked write no pulses", npulse, np0);

    // R4 R5 R6 R7 R12: table of source, pre-divide and N settings
    for (int i = 0; i < 8; i++) begin
      write_cfg(VEC_CFG[i], 1'b1);
      wait_pulses(2);
      t0 = last_cyc;
      wait_pulses(8);
      chk(last_cyc - t0 == VEC_CYC[i], $sformatf("R4 R5 R6 R7 R12 vector %0d", i),
          last_cyc - t0, VEC_CYC[i]);
    end

    // R6: alternating 2 and 3 on the crystal
    write_cfg(32'h8000_0200, 1'b1);
    wait_pulses(4);
    chk(hist[npulse % 64] + hist[(npulse - 1) % 64] == 5 &&
        hist[npulse % 64] != hist[(npulse - 1) % 64],
        "R6 alternating pair", hist[npulse % 64] * 10 + hist[(npulse - 1) % 64], 23);

    // R9: change mid-period, 12-cycle period then 2
    write_cfg(32'h8000_0304, 1'b1);
    wait_pulses(2);
    np0 = npulse;
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; cfg_unlock = 1'b1; cfg_wdata = 32'h8000_0101;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_unlock = 1'b0;
    wait_pulses(np0 + 2 - npulse);
    chk(hist[(np0 + 1) % 64] == 12, "R9 old period kept", hist[(np0 + 1) % 64], 12);
    chk(hist[(np0 + 2) % 64] == 2, "R9 new period", hist[(np0 + 2) % 64], 2);

    // R10: write on the closing edge of a 6-cycle period
    write_cfg(32'h8000_0103, 1'b1);
    wait_pulses(2);
    np0 = npulse;
    repeat (5) @(negedge clk);
    cfg_wr = 1'b1; cfg_unlock = 1'b1; cfg_wdata = 32'h8000_0301;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_unlock = 1'b0;
    wait_pulses(np0 + 3 - npulse);
    chk(hist[(np0 + 1) % 64] == 6, "R10 first interval", hist[(np0 + 1) % 64], 6);
    chk(hist[(np0 + 2) % 64] == 6, "R10 deferred interval", hist[(np0 + 2) % 64], 6);
    chk(hist[(np0 + 3) % 64] == 3, "R10 new interval", hist[(np0 + 3) % 64], 3);

    // R8: pre code 00 and enable clear both silent
    write_cfg(32'h8000_0003, 1'b1);
    repeat (4) @(negedge clk);
    np0 = npulse;
    repeat (200) @(negedge clk);
    chk(npulse == np0, "R8 code 00 silent", npulse, np0);
    write_cfg(32'h0000_0105, 1'b1);
    repeat (4) @(negedge clk);
    np0 = npulse;
    repeat (200) @(negedge clk);
    chk(npulse == np0, "R8 enable clear silent", npulse, np0);

    // R11: stop in the middle of a 381-cycle period
    write_cfg(32'h8000_037F, 1'b1);
    wait_pulses(1);
    repeat (20) @(negedge clk);
    write_cfg(32'h0000_037F, 1'b1);
    repeat (2) @(negedge clk);
    np0 = npulse;
    repeat (500) @(negedge clk);
    chk(npulse == np0, "R11 immediate stop", npulse, np0);
    chk(cfg_rdata == 32'h0000_037F, "R3 readback after stop", cfg_rdata, 32'h0000_037F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule